// File: doc/BRIEF.md
# Two-Wire Bus Condition Status Register

This block turns the condition flags of a two-wire (I2C) serial controller into a single status byte for the processor. The flags are the operating mode, START or repeated START sent, address or data phase, acknowledge seen, arbitration lost, general call, STOP received, last byte and bus error. The block squeezes them into a 5-bit code, and each distinct bus situation gets its own code. The code sits in the upper five bits of the byte and the lower three bits are zero. Software can therefore use the byte directly as a jump-table offset, with service routines eight locations apart.

The protocol engine holds `raise` high when it wants to request the serial interrupt. While the interrupt flag is clear, that request latches the current code and sets the flag. After that, the byte is frozen until software pulses `sw_clear`. A request that is still held when the flag clears is taken on the following cycle. While no status is pending, the byte shows the idle value 0xF8. Pulling `enable` low drops any pending status.

Top module: `i2cst_status_reg`

## Requirements
- R1: After reset, and at any time the interrupt flag is clear, `status_byte` reads 0xF8 and `irq_flag` is 0.
- R2: Bits 2..0 of `status_byte` are always 0.
- R3: When `enable`=1, `raise`=1 and `irq_flag`=0 at a clock edge, then after that edge `irq_flag`=1 and `status_byte` holds the code for the inputs at that edge. `bus_err`=1 gives 0x00 and overrides every other input.
- R4: In the master modes (`mode` 0 = master transmit, 1 = master receive), the priority is `st_sent` (0x08), then `rst_sent` (0x10), then `arb_lost` (0x38).
- R5: Master transmit codes are address 0x18 with ACK and 0x20 without, and data 0x28 with ACK and 0x30 without. Master receive codes are address 0x40 with ACK and 0x48 without, and data 0x50 with ACK and 0x58 without. `ack`=1 means acknowledge, and `addr_ph`=1 selects the address phase.
- R6: In slave receive (`mode` 2), `stop_rx` gives 0xA0 and takes priority. The address phase gives 0x60, with +0x08 if `arb_lost` and +0x10 if `gen_call`. The data phase gives 0x80, with +0x10 if `gen_call` and +0x08 if `ack`=0.
- R7: In slave transmit (`mode` 3), the address phase gives 0xA8, with +0x08 if `arb_lost`. The data phase gives 0xC8 if `last_byte`=1, otherwise 0xB8 with ACK and 0xC0 without.
- R8: While `irq_flag`=1, `enable`=1 and `sw_clear`=0, the status byte and the flag do not change, whatever `raise` and the condition inputs do.
- R9: `sw_clear`=1 while `irq_flag`=1 clears the flag and gives 0xF8 after the edge, even if `raise` is high in the same cycle. A `raise` still held on the next edge is then captured.
- R10: While `enable`=0, the flag is cleared and the byte reads 0xF8 after the next edge, and `raise` has no effect.
- R11: `sw_clear` while `irq_flag`=0 has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| enable | input | 1 | Serial unit enabled |
| mode | input | 2 | 0 master tx, 1 master rx, 2 slave rx, 3 slave tx |
| bus_err | input | 1 | Illegal START or STOP position seen |
| st_sent | input | 1 | START sent (master) |
| rst_sent | input | 1 | Repeated START sent (master) |
| addr_ph | input | 1 | 1 = address phase ended, 0 = data phase ended |
| ack | input | 1 | Acknowledge bit was low (ACK) |
| arb_lost | input | 1 | Arbitration lost |
| gen_call | input | 1 | Addressed by general call |
| stop_rx | input | 1 | STOP or repeated START received while addressed |
| last_byte | input | 1 | Last slave-transmit byte sent |
| raise | input | 1 | Interrupt request from the protocol engine (held level) |
| sw_clear | input | 1 | Software clears the interrupt flag |
| status_byte | output | 8 | Status code in bits 7..3, bits 2..0 zero |
| irq_flag | output | 1 | Serial interrupt flag |

## Verification
The bench sweeps all four modes against every combination of the nine condition flags. Each expected byte is computed from the arithmetic offsets in the requirements. A wrong priority, for example a STOP losing to the address phase, or bus error failing to override, shows up as a wrong byte in some combination. For each combination the bench also:
- changes the flags and raises again while the flag is set. A design that recaptures would show the new code instead of the frozen one.
- asserts clear and raise together. A design that lets the raise win would never show 0xF8, and one that drops a held request would miss the capture on the next cycle.
- exercises disable and a stray clear with no status pending.

// File: rtl/i2cst_pkg.sv
package i2cst_pkg;
  localparam int CODE_W = 5;
  localparam int LOW_W  = 3;
  localparam int STAT_W = CODE_W + LOW_W;
  localparam logic [CODE_W-1:0] CODE_IDLE = '1;
  localparam logic [CODE_W-1:0] CODE_BERR = '0;

  typedef enum logic [1:0] {
    MD_MTX = 2'd0,
    MD_MRX = 2'd1,
    MD_SRX = 2'd2,
    MD_STX = 2'd3
  } mode_e;

  typedef struct packed {
    logic berr;
    logic start;
    logic rstart;
    logic addr;
    logic ack;
    logic arb;
    logic gcall;
    logic stop;
    logic last;
  } cond_t;

  function automatic logic [CODE_W-1:0] st_code(input int n);
    return CODE_W'(n);
  endfunction

  function automatic logic [CODE_W-1:0] st_encode(input mode_e m, input cond_t c);
    logic [CODE_W-1:0] r;
    if (c.berr) begin
      r = CODE_BERR;
    end else begin
      unique case (m)
        MD_MTX, MD_MRX: begin
          if (c.start)       r = st_code(1);
          else if (c.rstart) r = st_code(2);
          else if (c.arb)    r = st_code(7);
          else if (m == MD_MTX)
            r = c.addr ? (c.ack ? st_code(3) : st_code(4))
                       : (c.ack ? st_code(5) : st_code(6));
          else
            r = c.addr ? (c.ack ? st_code(8) : st_code(9))
                       : (c.ack ? st_code(10) : st_code(11));
        end
        MD_SRX: begin
          if (c.stop)      r = st_code(20);
          else if (c.addr) r = c.gcall ? (c.arb ? st_code(15) : st_code(14))
                                       : (c.arb ? st_code(13) : st_code(12));
          else             r = c.gcall ? (c.ack ? st_code(18) : st_code(19))
                                       : (c.ack ? st_code(16) : st_code(17));
        end
        default: begin
          if (c.addr)      r = c.arb ? st_code(22) : st_code(21);
          else if (c.last) r = st_code(25);
          else             r = c.ack ? st_code(23) : st_code(24);
        end
      endcase
    end
    return r;
  endfunction

  function automatic logic [STAT_W-1:0] st_byte(input logic [CODE_W-1:0] code);
    return {code, LOW_W'(0)};
  endfunction
endpackage

// File: rtl/i2cst_encoder.sv
module i2cst_encoder
  import i2cst_pkg::*;
(
  input  mode_e             mode,
  input  cond_t             cond,
  output logic [CODE_W-1:0] code
);
  always_comb code = st_encode(mode, cond);
endmodule

// File: rtl/i2cst_hold.sv
module i2cst_hold
  import i2cst_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              enable,
  input  logic              raise,
  input  logic              sw_clear,
  input  logic [CODE_W-1:0] code_in,
  output logic [CODE_W-1:0] code_q,
  output logic              irq_q,
  output logic              cap_fire,
  output logic              clr_fire
);
  assign cap_fire = enable && raise && !irq_q;
  assign clr_fire = irq_q && (sw_clear || !enable);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      irq_q  <= 1'b0;
      code_q <= CODE_IDLE;
    end else if (clr_fire) begin
      irq_q  <= 1'b0;
      code_q <= CODE_IDLE;
    end else if (cap_fire) begin
      irq_q  <= 1'b1;
      code_q <= code_in;
    end
  end
endmodule

// File: rtl/i2cst_status_reg.sv
module i2cst_status_reg
  import i2cst_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              enable,
  input  logic [1:0]        mode,
  input  logic              bus_err,
  input  logic              st_sent,
  input  logic              rst_sent,
  input  logic              addr_ph,
  input  logic              ack,
  input  logic              arb_lost,
  input  logic              gen_call,
  input  logic              stop_rx,
  input  logic              last_byte,
  input  logic              raise,
  input  logic              sw_clear,
  output logic [STAT_W-1:0] status_byte,
  output logic              irq_flag
);
  cond_t             cond;
  logic [CODE_W-1:0] code_now;
  logic [CODE_W-1:0] code_held;
  logic              cap_fire;
  logic              clr_fire;

  always_comb begin
    cond.berr   = bus_err;
    cond.start  = st_sent;
    cond.rstart = rst_sent;
    cond.addr   = addr_ph;
    cond.ack    = ack;
    cond.arb    = arb_lost;
    cond.gcall  = gen_call;
    cond.stop   = stop_rx;
    cond.last   = last_byte;
  end

  i2cst_encoder u_enc (
    .mode (mode_e'(mode)),
    .cond (cond),
    .code (code_now)
  );

  i2cst_hold u_hold (
    .clk      (clk),
    .rst_n    (rst_n),
    .enable   (enable),
    .raise    (raise),
    .sw_clear (sw_clear),
    .code_in  (code_now),
    .code_q   (code_held),
    .irq_q    (irq_flag),
    .cap_fire (cap_fire),
    .clr_fire (clr_fire)
  );

  assign status_byte = st_byte(code_held);
endmodule

// File: rtl/i2cst_status_chk.sv
module i2cst_status_chk
  import i2cst_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              enable,
  input logic              raise,
  input logic              sw_clear,
  input logic [STAT_W-1:0] status_byte,
  input logic              irq_flag
);
  localparam logic [STAT_W-1:0] IDLE_BYTE = {CODE_IDLE, LOW_W'(0)};

  AST_IDLE_WHEN_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    !irq_flag |-> status_byte == IDLE_BYTE); // R1
  AST_LOW_BITS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    status_byte[LOW_W-1:0] == '0); // R2
  AST_CAPTURE_SETS: assert property (@(posedge clk) disable iff (!rst_n)
    enable && raise && !irq_flag |=> irq_flag); // R3
  AST_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    irq_flag && enable && !sw_clear |=> irq_flag && $stable(status_byte)); // R8
  AST_CLEAR_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    irq_flag && sw_clear |=> !irq_flag && status_byte == IDLE_BYTE); // R9
  AST_DISABLED: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> !irq_flag && status_byte == IDLE_BYTE); // R10
endmodule

bind i2cst_status_reg i2cst_status_chk u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .enable      (enable),
  .raise       (raise),
  .sw_clear    (sw_clear),
  .status_byte (status_byte),
  .irq_flag    (irq_flag)
);

// File: tb/sim_i2cst_status_reg.sv
`timescale 1ns/100ps
module sim_i2cst_status_reg;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic enable = 1'b0;
  logic [1:0] mode = 2'd0;
  logic [8:0] fl = 9'd0;
  logic raise = 1'b0;
  logic sw_clear = 1'b0;
  logic [7:0] status_byte;
  logic irq_flag;
  int n_cmp = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  i2cst_status_reg u0 (
    .clk(clk), .rst_n(rst_n), .enable(enable), .mode(mode),
    .bus_err(fl[8]), .st_sent(fl[7]), .rst_sent(fl[6]), .addr_ph(fl[5]),
    .ack(fl[4]), .arb_lost(fl[3]), .gen_call(fl[2]), .stop_rx(fl[1]),
    .last_byte(fl[0]), .raise(raise), .sw_clear(sw_clear),
    .status_byte(status_byte), .irq_flag(irq_flag)
  );

  function automatic logic [7:0] ref_byte(input int m, input logic [8:0] f);
    int nak;
    nak = f[4] ? 0 : 1;
    if (f[8]) return 8'h00;                                    // R3
    if (m <= 1) begin                                          // R4
      if (f[7]) return 8'h08;
      if (f[6]) return 8'h10;
      if (f[3]) return 8'h38;
      if (m == 0) return 8'(f[5] ? 'h18 + 8*nak : 'h28 + 8*nak); // R5
      return 8'(f[5] ? 'h40 + 8*nak : 'h50 + 8*nak);
    end
    if (m == 2) begin                                          // R6
      if (f[1]) return 8'hA0;
      if (f[5]) return 8'('h60 + 8*int'(f[3]) + 16*int'(f[2]));
      return 8'('h80 + 16*int'(f[2]) + 8*nak);
    end
    if (f[5]) return 8'('hA8 + 8*int'(f[3]));                  // R7
    if (f[0]) return 8'hC8;
    return 8'('hB8 + 8*nak);
  endfunction

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %02h expected %02h (mode %0d flags %09b)", req, act, exp, mode, fl);
    end
  endtask

  task automatic tick;
    @(negedge clk);
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    tick; tick;
    chk("R1", status_byte, 8'hF8);
    chk("R1", {7'd0, irq_flag}, 8'd0);
    rst_n = 1'b1; enable = 1'b1;
    tick;
    // R11: stray clear with nothing pending
    sw_clear = 1'b1; tick; sw_clear = 1'b0;
    chk("R11", status_byte, 8'hF8);
    chk("R11", {7'd0, irq_flag}, 8'd0);

    for (int m = 0; m < 4; m++) begin
      for (int f = 0; f < 512; f++) begin
        logic [7:0] e;
        mode = 2'(m); fl = 9'(f);
        e = ref_byte(m, fl);
        raise = 1'b1; tick;
        chk("R3", {7'd0, irq_flag}, 8'd1);
        chk("R4-R7 code", status_byte, e);
        chk("R2", {5'd0, status_byte[2:0]}, 8'd0);
        // R8: new request with other flags while flag is set
        fl = ~9'(f); mode = 2'(3 - m); tick;
        chk("R8", status_byte, e);
        chk("R8", {7'd0, irq_flag}, 8'd1);
        // R9: clear and raise together, clear wins
        sw_clear = 1'b1; tick; sw_clear = 1'b0;
        chk("R9", status_byte, 8'hF8);
        chk("R9", {7'd0, irq_flag}, 8'd0);
        // R9: held request captured afterwards
        tick; raise = 1'b0;
        chk("R9", status_byte, ref_byte(3 - m, ~9'(f)));
        sw_clear = 1'b1; tick; sw_clear = 1'b0;
        chk("R1", status_byte, 8'hF8);
      end
    end

    // R10: disable drops pending status and blocks raise
    mode = 2'd2; fl = 9'b0_0010_0000;
    raise = 1'b1; tick; raise = 1'b0;
    chk("R10 setup", status_byte, 8'h60);
    enable = 1'b0; tick;
    chk("R10", status_byte, 8'hF8);
    chk("R10", {7'd0, irq_flag}, 8'd0);
    raise = 1'b1; tick; tick;
    chk("R10", status_byte, 8'hF8);
    chk("R10", {7'd0, irq_flag}, 8'd0);
    enable = 1'b1; tick; raise = 1'b0;
    chk("R10 re-enable", status_byte, 8'h60);
    // reset returns to idle
    rst_n = 1'b0; tick;
    chk("R1", status_byte, 8'hF8);
    chk("R1", {7'd0, irq_flag}, 8'd0);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule